// File: doc/BRIEF.md
# Seat Belt Reminder Alarm Controller

This block asks the driver to buckle up. It watches three single-cycle event inputs: ignition key switched on, ignition key switched off, and belt fastened. It also watches a one-second tick strobe that is generated elsewhere. When the key goes on, a control machine starts an internal seconds timer. If the belt is still unfastened when the warning mark is reached, the machine raises a level alarm output.

The alarm stays up until the first of three things happens: the stop mark of the timer, the belt being fastened, or the key being switched off. The control machine and the timer step together on one clock edge, as a single product machine. The machine drives the timer's start and clear commands, and the timer reports its two marks back in the same cycle. The current control phase is also brought out as a two-bit code so that it can be observed.

Top module: `sbr_alarm_ctrl`

## Requirements
- R1: While reset is held and after it is released, the phase code is 0 (idle) and the alarm output is low.
- R2: In idle (code 0), a key-on event moves the phase to waiting (code 1) on the next clock edge and restarts the seconds count from zero. A tick in that same cycle is not counted.
- R3: In waiting, a key-off or belt event returns the phase to idle on the next edge, and the alarm never rises.
- R4: In waiting, the fifth tick counted since the key-on moves the phase to alarming (code 2) on that tick's clock edge.
- R5: In alarming, the tenth tick counted since the key-on returns the phase to idle on that tick's clock edge.
- R6: In alarming, a key-off or belt event returns the phase to idle on the next edge.
- R7: When no transition condition holds, the phase stays where it is. Key-on while waiting or alarming neither restarts nor alters the count. Key-off and belt events in idle have no effect.
- R8: In waiting, a key-off or belt event in the same cycle as the fifth tick wins: the phase goes to idle and the alarm does not rise.
- R9: The timer is held cleared while idle. Ticks seen in idle do not count toward the next start.
- R10: The alarm output is registered. It equals one exactly one clock after the phase code is 2, and zero one clock after any other phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_on_i | input | 1 | One-cycle pulse: ignition key switched on |
| key_off_i | input | 1 | One-cycle pulse: ignition key switched off |
| belt_i | input | 1 | One-cycle pulse: seat belt fastened |
| sec_tick_i | input | 1 | One-cycle strobe, once per second |
| phase_o | output | 2 | Control phase: 0 idle, 1 waiting, 2 alarming |
| alarm_o | output | 1 | Registered alarm level |

## Verification
The sweep starts the machine with a key-on and then applies every tick count from zero to eleven. The run ends with no exit event, a key-off, a belt event, or both, so each of the WAIT and ALARM exits is exercised on every tick boundary. An option places the exit event on the same cycle as a tick. This separates the priority of an exit over the fifth mark from an off-by-one in the timer. Another option injects extra key-on pulses mid-count, which would expose a timer that restarts on them. Ticks are also sent while idle before every scenario, which would expose a timer that keeps counting when it should be held cleared.

// File: rtl/sbr_pkg.sv
// Shared types for the seat belt reminder controller.
package sbr_pkg;
    // Control phase; the encoding is visible on phase_o.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_ALARM = 2'd2
    } phase_e;
endpackage

// File: rtl/sbr_sec_timer.sv
// Seconds timer. It counts tick strobes after a start command.
// It flags the warning mark and the stop mark on the tick that reaches each one.
// Assumes WARN_TICKS < STOP_TICKS. Start dominates clear.
// Reaching the stop mark returns the timer to its cleared state.
module sbr_sec_timer #(
    parameter int WARN_TICKS = 5,
    parameter int STOP_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clear_i,
    input  logic tick_i,
    output logic warn_mark_o,
    output logic stop_mark_o
);
    localparam int CNT_W = $clog2(STOP_TICKS + 1);
    localparam logic [CNT_W-1:0] WARN_LAST = CNT_W'(WARN_TICKS - 1);
    localparam logic [CNT_W-1:0] STOP_LAST = CNT_W'(STOP_TICKS - 1);

    logic [CNT_W-1:0] count_q;
    logic             run_q;
    logic             tick_seen;

    assign tick_seen   = run_q && tick_i;
    assign warn_mark_o = tick_seen && (count_q == WARN_LAST);
    assign stop_mark_o = tick_seen && (count_q == STOP_LAST);

    // Count register: restart, clear, or advance on a counted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (start_i) begin
            count_q <= '0;
            run_q   <= 1'b1;
        end else if (clear_i || stop_mark_o) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (tick_seen) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/sbr_ctrl_fsm.sv
// Three-phase control machine. It steps in lock-step with the seconds timer.
// It issues the timer's start and clear commands.
// Exit events take priority over the timer's marks.
module sbr_ctrl_fsm
    import sbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   key_on_i,
    input  logic   key_off_i,
    input  logic   belt_i,
    input  logic   warn_mark_i,
    input  logic   stop_mark_i,
    output phase_e phase_o,
    output logic   tmr_start_o,
    output logic   tmr_clear_o
);
    phase_e phase_q, phase_d;
    logic   leave_evt;

    assign leave_evt   = key_off_i || belt_i;
    assign tmr_start_o = (phase_q == PH_IDLE) && key_on_i;
    assign tmr_clear_o = (phase_q == PH_IDLE);
    assign phase_o     = phase_q;

    // Next-phase selection; no matching condition keeps the phase.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (key_on_i) phase_d = PH_WAIT;
            PH_WAIT: begin
                if (leave_evt)        phase_d = PH_IDLE;
                else if (warn_mark_i) phase_d = PH_ALARM;
            end
            PH_ALARM: if (leave_evt || stop_mark_i) phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/sbr_alarm_out.sv
// Output stage: registers the alarm level from the current phase (Moore output).
module sbr_alarm_out
    import sbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_i,
    output logic   alarm_o
);
    // Alarm register, one clock behind the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm_o <= 1'b0;
        else        alarm_o <= (phase_i == PH_ALARM);
    end
endmodule

// File: rtl/sbr_alarm_ctrl.sv
// Seat belt reminder top level. Joins the control machine, the seconds timer and
// the registered alarm stage into one synchronous product machine.
// Assumes the event inputs are already debounced single-cycle pulses.
module sbr_alarm_ctrl
    import sbr_pkg::*;
#(
    parameter int WARN_TICKS = 5,
    parameter int STOP_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_on_i,
    input  logic       key_off_i,
    input  logic       belt_i,
    input  logic       sec_tick_i,
    output logic [1:0] phase_o,
    output logic       alarm_o
);
    phase_e phase;
    logic   tmr_start, tmr_clear, warn_mark, stop_mark;

    sbr_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_on_i   (key_on_i),
        .key_off_i  (key_off_i),
        .belt_i     (belt_i),
        .warn_mark_i(warn_mark),
        .stop_mark_i(stop_mark),
        .phase_o    (phase),
        .tmr_start_o(tmr_start),
        .tmr_clear_o(tmr_clear)
    );

    sbr_sec_timer #(
        .WARN_TICKS(WARN_TICKS),
        .STOP_TICKS(STOP_TICKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (tmr_start),
        .clear_i    (tmr_clear),
        .tick_i     (sec_tick_i),
        .warn_mark_o(warn_mark),
        .stop_mark_o(stop_mark)
    );

    sbr_alarm_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_i(phase),
        .alarm_o(alarm_o)
    );

    assign phase_o = phase;
endmodule

// File: rtl/sbr_alarm_ctrl_chk.sv
// Property checker for sbr_alarm_ctrl, attached through bind.
module sbr_alarm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       key_on_i,
    input logic       key_off_i,
    input logic       belt_i,
    input logic [1:0] phase_o,
    input logic       alarm_o
);
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) phase_o != 2'd3); // R1
    AST_IDLE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0 && key_on_i) |=> phase_o == 2'd1); // R2
    AST_WAIT_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1 && (key_off_i || belt_i)) |=> phase_o == 2'd0); // R3
    AST_ALARM_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && (key_off_i || belt_i)) |=> phase_o == 2'd0); // R6
    AST_IDLE_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0) |=> phase_o != 2'd2); // R7
    AST_ALARM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2) |=> alarm_o); // R10
    AST_ALARM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd2) |=> !alarm_o); // R10
endmodule

bind sbr_alarm_ctrl sbr_alarm_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_on_i (key_on_i),
    .key_off_i(key_off_i),
    .belt_i   (belt_i),
    .phase_o  (phase_o),
    .alarm_o  (alarm_o)
);

// File: tb/sbr_alarm_ctrl_tb.sv
// Sweep bench for sbr_alarm_ctrl with the default 5/10 tick marks.
module sbr_alarm_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_on = 1'b0, key_off = 1'b0, belt = 1'b0, tick = 1'b0;
    logic [1:0] phase;
    logic       alarm;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    sbr_alarm_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_on_i  (key_on),
        .key_off_i (key_off),
        .belt_i    (belt),
        .sec_tick_i(tick),
        .phase_o   (phase),
        .alarm_o   (alarm)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One stimulus cycle. Afterwards the phase result is visible at the sampling negedge.
    task automatic step(input bit kon, input bit koff, input bit blt, input bit tk);
        @(negedge clk);
        key_on = kon; key_off = koff; belt = blt; tick = tk;
        @(negedge clk);
        key_on = 0; key_off = 0; belt = 0; tick = 0;
    endtask

    // Phase expected after c ticks counted since key-on (stop mark returns to idle).
    function automatic int exp_phase(input int c);
        if (c < 5)  return 1;
        if (c < 10) return 2;
        return 0;
    endfunction

    task automatic scenario(input int n, input int kind, input bit coinc, input bit kon_extra);
        int ph;
        // R9: ticks and exit events while idle must not count or change anything.
        for (int i = 0; i < 7; i++) step(0, i == 3, i == 5, 1);
        check("R9 idle", phase, 0);
        step(1, 0, 0, 1);                     // tick in start cycle is not counted
        check("R2 enter wait", phase, 1);
        ph = 1;
        for (int t = 1; t <= n; t++) begin
            step(0, 0, 0, 1);
            ph = exp_phase(t);
            check(t == 5 ? "R4 warn mark" : (t == 10 ? "R5 stop mark" : "R7 hold"), phase, ph);
            @(negedge clk);
            check("R10 alarm level", alarm, ph == 2);
            if (kon_extra && (t == 3 || t == 7)) begin
                step(1, 0, 0, 0);
                check("R7 key-on ignored", phase, ph);
            end
        end
        if (kind != 0) begin
            step(0, kind[0], kind[1], coinc);
            if (ph == 1 && coinc && n == 4) check("R8 exit beats warn", phase, 0);
            else if (ph == 2)               check("R6 alarm exit", phase, 0);
            else if (ph == 1)               check("R3 wait exit", phase, 0);
            else                            check("R7 idle ignores exit", phase, 0);
            @(negedge clk);
            check(ph == 2 ? "R10 alarm falls" : "R3 no alarm", alarm, 0);
        end else if (ph != 0) begin
            step(0, 1, 0, 0);
            check("R3 key-off exit", phase, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset phase", phase, 0);
        check("R1 reset alarm", alarm, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", phase, 0);
        for (int n = 0; n < 12; n++)
            for (int k = 0; k < 4; k++)
                for (int c = 0; c < 2; c++)
                    for (int x = 0; x < 2; x++)
                        if (!(k == 0 && c == 1)) scenario(n, k, c[0], x[0]);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule